// File: doc/BRIEF.md
# Debug Trace Capture Buffer

This block is the storage side of an on-chip debug tracer. It holds up to eight captured words in first-in, first-out order. The words are either change-of-flow addresses or data bus values. Outside logic (comparators, breakpoint logic, the serial debug link) supplies the trigger pulses and capture strobes. The block decides which strobes are stored, keeps a count of the valid words, and hands the words back through a read port in the order they were taken.

A run starts with an arm pulse, which also empties the buffer. In flow mode, storing is gated by a window that a begin trigger opens and an end trigger closes. In data mode, every strobe is stored while the block is armed. The run stops on its own when the eighth word lands. It also stops when software disarms it. A manual disarm with a partly filled buffer drops the oldest stored word, so the readout starts one position later.

Top module: `cof_trace_buf`

## Requirements
- R1: After reset, `armed` is 0, `count` is 0 and `rd_data` is 0.
- R2: An `arm_set` pulse empties the buffer and raises `armed`. Both take effect at the next clock edge and override every other input in that cycle.
- R3: In flow mode (`mode_data`=0), a strobe stores `cap_addr` only when the window is open. The window opens at the edge after a `begin_trig` cycle, so a strobe in the trigger cycle itself is not stored. A strobe in the same cycle as `end_trig` is still stored, and later strobes are not.
- R4: In data mode (`mode_data`=1), each strobe while armed stores `cap_data` zero-extended into the upper bits. The begin and end triggers have no effect in this mode.
- R5: `count` equals the number of valid stored words and changes at the clock edge that stores or removes a word. It never exceeds 8.
- R6: Words are read out in the order in which they were stored.
- R7: When the eighth word is stored, `armed` falls at that same edge and `count` reads binary 1000. Strobes after that are ignored.
- R8: A read (`rd_en`) with `count` nonzero puts the oldest word on `rd_data` after the edge and lowers `count` by one.
- R9: A read of an empty buffer drives `rd_data` to 0 and leaves `count` at 0.
- R10: An `arm_clr` pulse while armed clears `armed` at the next edge. If `count` is between 1 and 7, the oldest word is also dropped and `count` falls by one. Strobes and reads in the `arm_clr` cycle are ignored. An `arm_clr` while disarmed changes nothing.
- R11: Strobes while disarmed store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_data | input | 1 | 0 = change-of-flow addresses gated by triggers, 1 = data values |
| arm_set | input | 1 | Pulse: empty the buffer and start a run |
| arm_clr | input | 1 | Pulse: manual stop of the run |
| begin_trig | input | 1 | Opens the storing window (flow mode) |
| end_trig | input | 1 | Closes the storing window (flow mode) |
| cap_stb | input | 1 | Capture strobe |
| cap_addr | input | WORD_W | Address word stored in flow mode |
| cap_data | input | DATA_W | Data value stored in data mode |
| rd_en | input | 1 | Pop the oldest word |
| armed | output | 1 | Run in progress |
| count | output | $clog2(DEPTH)+1 | Number of valid words |
| rd_data | output | WORD_W | Word returned by the last read |

## Verification
Every result is registered once. `count`, `armed` and `rd_data` therefore change at the first rising edge after the stimulus cycle. The one exception is the trigger window, which adds one more edge before a strobe can be stored. The bench applies inputs on the falling edge and samples on the next falling edge, so each check reads the value produced by exactly one rising edge. For the begin trigger, the bench places its strobes one cycle later so the extra register delay is covered.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
   typedef enum logic {
      MODE_FLOW = 1'b0,
      MODE_DATA = 1'b1
   } cap_mode_e;
endpackage

// File: rtl/dtf_ctrl.sv
module dtf_ctrl #(
   parameter int DEPTH = 8,
   parameter int CW    = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dtf_pkg::cap_mode_e mode,
   input  logic              arm_set,
   input  logic              arm_clr,
   input  logic              begin_trig,
   input  logic              end_trig,
   input  logic              cap_stb,
   input  logic              rd_en,
   input  logic [CW-1:0]     count,
   output logic              armed,
   output logic              do_clear,
   output logic              do_push,
   output logic              do_pop,
   output logic              rd_take,
   output logic              rd_zero
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [CW-1:0] LAST_CNT = CW'(DEPTH - 1);

   logic gate_q, quiet, empty, full, drop;

   always_comb begin
      quiet    = !arm_set && !arm_clr;
      empty    = (count == '0);
      full     = (count == FULL_CNT);
      do_clear = arm_set;
      drop     = arm_clr && !arm_set && armed && !empty && !full;
      do_push  = quiet && armed && cap_stb && !full &&
                 ((mode == dtf_pkg::MODE_DATA) || gate_q);
      rd_take  = quiet && rd_en && !empty;
      rd_zero  = quiet && rd_en && empty;
      do_pop   = drop || rd_take;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (arm_set) begin
         armed <= 1'b1;
      end else if (arm_clr) begin
         armed <= 1'b0;
      end else if (do_push && !rd_take && count == LAST_CNT) begin
         armed <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
      end else if (arm_set || arm_clr || !armed) begin
         gate_q <= 1'b0;
      end else if (end_trig) begin
         gate_q <= 1'b0;
      end else if (begin_trig && mode == dtf_pkg::MODE_FLOW) begin
         gate_q <= 1'b1;
      end
   end

   assert_full_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (count == FULL_CNT) |-> !armed);
   assert_arm_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      arm_set |=> (armed && count == '0));
   assert_manual_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_clr && !arm_set) |=> !armed);
   assert_idle_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !arm_set) |=> (count <= $past(count)));
endmodule

// File: rtl/dtf_store.sv
module dtf_store #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 8,
   parameter int CW     = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              do_clear,
   input  logic              do_push,
   input  logic              do_pop,
   input  logic              rd_take,
   input  logic              rd_zero,
   input  logic [WORD_W-1:0] din,
   output logic [CW-1:0]     count,
   output logic [WORD_W-1:0] rd_data
);
   localparam int PW = $clog2(DEPTH);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_bad
      $error("dtf_store: DEPTH must be a power of two of at least 2");
   end

   logic [WORD_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wr_ptr, rd_ptr;

   always_ff @(posedge clk) begin
      if (do_push && !do_clear) begin
         mem[wr_ptr] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (do_clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + PW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + PW'(1);
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_take) begin
         rd_data <= mem[rd_ptr];
      end else if (rd_zero) begin
         rd_data <= '0;
      end
   end

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);
   assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_zero |=> (rd_data == '0));
   assert_pop_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_take && !do_push && !do_clear) |=> (count == $past(count) - CW'(1)));
endmodule

// File: rtl/cof_trace_buf.sv
module cof_trace_buf #(
   parameter int WORD_W = 16,
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       mode_data,
   input  logic                       arm_set,
   input  logic                       arm_clr,
   input  logic                       begin_trig,
   input  logic                       end_trig,
   input  logic                       cap_stb,
   input  logic [WORD_W-1:0]          cap_addr,
   input  logic [DATA_W-1:0]          cap_data,
   input  logic                       rd_en,
   output logic                       armed,
   output logic [$clog2(DEPTH):0]     count,
   output logic [WORD_W-1:0]          rd_data
);
   localparam int CW = $clog2(DEPTH) + 1;

   if (DATA_W > WORD_W) begin : g_width_bad
      $error("cof_trace_buf: DATA_W must not exceed WORD_W");
   end

   dtf_pkg::cap_mode_e mode;
   logic [WORD_W-1:0]  data_ext, din;
   logic do_clear, do_push, do_pop, rd_take, rd_zero;

   assign mode = dtf_pkg::cap_mode_e'(mode_data);

   if (DATA_W == WORD_W) begin : g_data_same
      assign data_ext = cap_data;
   end else begin : g_data_pad
      assign data_ext = {{(WORD_W - DATA_W){1'b0}}, cap_data};
   end

   assign din = (mode == dtf_pkg::MODE_DATA) ? data_ext : cap_addr;

   dtf_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .arm_set(arm_set), .arm_clr(arm_clr),
      .begin_trig(begin_trig), .end_trig(end_trig),
      .cap_stb(cap_stb), .rd_en(rd_en), .count(count),
      .armed(armed), .do_clear(do_clear), .do_push(do_push),
      .do_pop(do_pop), .rd_take(rd_take), .rd_zero(rd_zero)
   );

   dtf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .CW(CW)) u_store (
      .clk(clk), .rst_n(rst_n), .do_clear(do_clear),
      .do_push(do_push), .do_pop(do_pop),
      .rd_take(rd_take), .rd_zero(rd_zero), .din(din),
      .count(count), .rd_data(rd_data)
   );

   assert_data_zext_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (do_push && mode == dtf_pkg::MODE_DATA) |-> (din[DATA_W-1:0] == cap_data));
endmodule

// File: tb/cof_trace_buf_bench.sv
module cof_trace_buf_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_data = 1'b0, arm_set = 1'b0, arm_clr = 1'b0;
   logic        begin_trig = 1'b0, end_trig = 1'b0, cap_stb = 1'b0, rd_en = 1'b0;
   logic [15:0] cap_addr = '0;
   logic [7:0]  cap_data = '0;
   logic        armed;
   logic [3:0]  count;
   logic [15:0] rd_data;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cof_trace_buf u_cof_trace_buf (
      .clk(clk), .rst_n(rst_n), .mode_data(mode_data),
      .arm_set(arm_set), .arm_clr(arm_clr),
      .begin_trig(begin_trig), .end_trig(end_trig),
      .cap_stb(cap_stb), .cap_addr(cap_addr), .cap_data(cap_data),
      .rd_en(rd_en), .armed(armed), .count(count), .rd_data(rd_data)
   );

   // [14] strobe, [13] begin, [12] end, [11:4] data, [3:0] expected count
   localparam logic [14:0] VEC [11] = '{
      {1'b1, 1'b0, 1'b0, 8'h11, 4'd1},
      {1'b0, 1'b1, 1'b0, 8'hE0, 4'd1},
      {1'b1, 1'b0, 1'b1, 8'h22, 4'd2},
      {1'b1, 1'b0, 1'b0, 8'h33, 4'd3},
      {1'b1, 1'b1, 1'b0, 8'h44, 4'd4},
      {1'b0, 1'b0, 1'b0, 8'hE1, 4'd4},
      {1'b1, 1'b0, 1'b0, 8'h55, 4'd5},
      {1'b1, 1'b0, 1'b1, 8'h66, 4'd6},
      {1'b1, 1'b0, 1'b0, 8'h77, 4'd7},
      {1'b1, 1'b0, 1'b0, 8'h88, 4'd8},
      {1'b1, 1'b0, 1'b0, 8'h99, 4'd8}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      arm_set = 0; arm_clr = 0; begin_trig = 0; end_trig = 0;
      cap_stb = 0; rd_en = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] expq[$];
      repeat (3) @(negedge clk);
      check("R1 armed", 32'(armed), 0);
      check("R1 count", 32'(count), 0);
      check("R1 rd_data", 32'(rd_data), 0);
      rst_n = 1;
      @(negedge clk);

      // R9: read of an empty buffer
      rd_data = rd_data;
      rd_en = 1; step(); idle();
      check("R9 empty read data", 32'(rd_data), 0);
      check("R9 empty read count", 32'(count), 0);

      // R11: strobe while disarmed
      mode_data = 1; cap_data = 8'h5A; cap_stb = 1; step(); idle();
      check("R11 disarmed strobe", 32'(count), 0);

      // R2: arm
      arm_set = 1; step(); idle();
      check("R2 armed", 32'(armed), 1);
      check("R2 count", 32'(count), 0);

      // R4/R5/R7: table walk in data mode
      for (int i = 0; i < 11; i++) begin
         cap_stb = VEC[i][14]; begin_trig = VEC[i][13]; end_trig = VEC[i][12];
         cap_data = VEC[i][11:4];
         if (VEC[i][14] && expq.size() < 8) expq.push_back({8'h00, VEC[i][11:4]});
         step(); idle();
         check("R5 count after vector", 32'(count), 32'(VEC[i][3:0]));
      end
      check("R7 armed clear at full", 32'(armed), 0);
      check("R7 count full 1000", 32'(count), 32'h8);

      // R6/R8/R4: readout order
      for (int i = 0; i < 8; i++) begin
         rd_en = 1; step(); idle();
         check("R6 R4 readout word", 32'(rd_data), 32'(expq[i]));
         check("R8 count after read", 32'(count), 32'(7 - i));
      end
      rd_en = 1; step(); idle();
      check("R9 read after drain", 32'(rd_data), 0);
      check("R9 count after drain", 32'(count), 0);

      // R3: flow mode trigger window
      mode_data = 0;
      arm_set = 1; step(); idle();
      cap_addr = 16'hA000; cap_stb = 1; step(); idle();
      check("R3 closed window", 32'(count), 0);
      cap_addr = 16'hA001; cap_stb = 1; begin_trig = 1; step(); idle();
      check("R3 strobe in begin cycle", 32'(count), 0);
      cap_addr = 16'hA002; cap_stb = 1; step(); idle();
      check("R3 open window", 32'(count), 1);
      cap_addr = 16'hA003; cap_stb = 1; end_trig = 1; step(); idle();
      check("R3 strobe in end cycle", 32'(count), 2);
      cap_addr = 16'hA004; cap_stb = 1; step(); idle();
      check("R3 after end", 32'(count), 2);

      // R10: manual disarm drops oldest
      cap_addr = 16'hA005; cap_stb = 1; arm_clr = 1; step(); idle();
      check("R10 armed after stop", 32'(armed), 0);
      check("R10 count after stop", 32'(count), 1);
      arm_clr = 1; step(); idle();
      check("R10 stop while disarmed", 32'(count), 1);
      rd_en = 1; step(); idle();
      check("R10 shifted readout", 32'(rd_data), 32'h0000A003);
      check("R10 count drained", 32'(count), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule